// File: doc/BRIEF.md
# Host bridge control register file

This block is the register front end of a PCI host bridge. A simple 32-bit register bus (16-bit byte address, write strobe, write data, combinational read data) reaches four live regions. The first is a bank of address-translation words. The second is a set of interrupt-map words, in which software controls only the enable bit. The third is a bank of plain PCI control words. The fourth is a reset control word, whose bits follow mixed write rules. Every other offset reads as zero and drops writes, including the flush window, the DMA error window and the diagnostic windows.

The reset control word drives a one-cycle system reset request. The block also counts resets to tell the first reset after power-up from later ones. A cold (power-up) reset starts a new history. A software power-on request clears that history, so the next warm reset counts as the first one again. The power-on status bit is loaded only on such a first reset. The reset counter saturates, so it never wraps back to "first".

Top module: `hbr_ctl_regs`

## Requirements
- R1: Three read/write translation words sit at 0x0200, 0x0204 and 0x0208. They keep their values across a warm reset (`rst`), and a cold reset (`cold_rst`) clears them to 0.
- R2: The flush window 0x020C–0x03FF, the DMA error window 0x0030–0x004F, the diagnostic windows 0x5000, 0xA400 and 0xA800, the window at 0xF000, and any other unlisted offset all read 0. Writes to these offsets change no register.
- R3: Twelve read/write PCI control words sit at 0x2000 + 4·k (k = 0..11). 0x2030 is unlisted and reads 0.
- R4: Interrupt map word k is live at 0x0C04 + 8·k (k = 0..7); the word at 0x0C00 + 8·k reads 0 and drops writes. A write to a live word changes only bit 31 (the enable bit). After a cold reset, word k reads 0x7C0 | (k << 2) with bit 31 clear. A warm reset clears bit 31 of every map word and leaves the other bits alone.
- R5: The reset control word is live at 0xF024; 0xF020 reads 0 and drops writes. Write data is masked to bits 31:27, and bits 26:0 always read 0.
- R6: On a write to 0xF024, a 1 in bit 31, 28 or 27 clears that bit, and a 1 in bit 30 or 29 sets that bit. A 0 in any bit leaves it unchanged. Bits 30 and 29 stay set until a first reset reloads the word.
- R7: A write to 0xF024 with bit 30 or bit 29 set drives `sys_reset_req` high for the cycle after the write edge. A write with neither bit set gives no pulse.
- R8: A write with bit 30 set clears the reset counter; a write with only bit 29 set leaves it unchanged. When both bits are set, the bit 30 behaviour applies.
- R9: A cold reset loads the reset word with 0x80000000 and makes the current reset the first one (`first_reset` = 1). A warm reset with the counter at zero loads 0x80000000 and sets `first_reset`. A warm reset with the counter nonzero leaves the reset word unchanged, and `first_reset` then reads 0.
- R10: The reset counter saturates. Any number of consecutive warm resets without a bit 30 write never sets `first_reset` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous active-high power-up reset |
| rst | input | 1 | Synchronous active-high warm reset |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe, write taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_reset_req | output | 1 | One-cycle system reset request |
| first_reset | output | 1 | High when the last reset was the first in the current history |

## Verification
Each bank is written with patterns that are distinct per word and then read back. This separates index decoding errors from data errors. The same writes aimed at the dead halves and neighbouring windows show whether a decoder lets stray writes alias into live words. The reset word is driven with single-bit, all-ones and masked-off patterns. These tell clear-on-one bits from set-on-one bits, and a pulse from no pulse. Warm reset sequences after a bit 29 write, a bit 30 write and a combined write tell a counter clear apart from no clear. A run of warm resets longer than the counter range exposes a counter that wraps.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 4;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_XLAT,
        RG_IMAP,
        RG_PCTL,
        RG_RCTL
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [IDX_W-1:0]   idx;
    } decode_t;

    localparam logic [ADDR_W-1:0] XLAT_BASE = 16'h0200;
    localparam logic [ADDR_W-1:0] IMAP_BASE = 16'h0C00;
    localparam logic [ADDR_W-1:0] PCTL_BASE = 16'h2000;
    localparam logic [ADDR_W-1:0] RCTL_LO   = 16'hF020;
    localparam logic [ADDR_W-1:0] RCTL_HI   = 16'hF027;

    // Reset word kept as bits 31:27 only; index 4 is bit 31, index 0 is bit 27.
    localparam int RC_W = 5;
    localparam logic [RC_W-1:0] RC_CLR_ON_ONE = 5'b10011;
    localparam logic [RC_W-1:0] RC_SET_ON_ONE = 5'b01100;
    localparam logic [RC_W-1:0] RC_POR_VALUE  = 5'b10000;
    localparam int RC_SOFT_POR = 3;
    localparam int RC_SOFT_XIR = 2;

    function automatic logic [DATA_W-2:0] imap_fixed(input int k);
        return 31'(32'h7C0 | (32'(k) << 2));
    endfunction

    function automatic logic [RC_W-1:0] rc_apply(input logic [RC_W-1:0] cur,
                                                 input logic [RC_W-1:0] wv);
        return (cur & ~(wv & RC_CLR_ON_ONE)) | (wv & RC_SET_ON_ONE);
    endfunction

endpackage

// File: rtl/hbr_decode.sv
module hbr_decode
    import hbr_pkg::*;
#(
    parameter int XLAT_N = 3,
    parameter int PCTL_N = 12,
    parameter int IMAP_N = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam logic [ADDR_W-1:0] XLAT_END = XLAT_BASE + ADDR_W'(4 * XLAT_N);
    localparam logic [ADDR_W-1:0] IMAP_END = IMAP_BASE + ADDR_W'(8 * IMAP_N);
    localparam logic [ADDR_W-1:0] PCTL_END = PCTL_BASE + ADDR_W'(4 * PCTL_N);

    logic [ADDR_W-1:0] off_x;
    logic [ADDR_W-1:0] off_i;
    logic [ADDR_W-1:0] off_p;

    always_comb begin
        off_x = addr - XLAT_BASE;
        off_i = addr - IMAP_BASE;
        off_p = addr - PCTL_BASE;
        dec.region = RG_NONE;
        dec.idx    = '0;
        if (addr >= XLAT_BASE && addr < XLAT_END) begin
            dec.region = RG_XLAT;
            dec.idx    = off_x[IDX_W+1:2];
        end else if (addr >= IMAP_BASE && addr < IMAP_END && addr[2]) begin
            dec.region = RG_IMAP;
            dec.idx    = off_i[IDX_W+2:3];
        end else if (addr >= PCTL_BASE && addr < PCTL_END) begin
            dec.region = RG_PCTL;
            dec.idx    = off_p[IDX_W+1:2];
        end else if (addr >= RCTL_LO && addr <= RCTL_HI && addr[2]) begin
            dec.region = RG_RCTL;
        end
    end
endmodule

// File: rtl/hbr_wordbank.sv
module hbr_wordbank
    import hbr_pkg::*;
#(
    parameter int N = 4
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] word_q [N];

    for (genvar k = 0; k < N; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (cold_rst) begin
                word_q[k] <= '0;
            end else if (we && idx == IDX_W'(k)) begin
                word_q[k] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N; k++) begin
            if (idx == IDX_W'(k)) rdata = word_q[k];
        end
    end
endmodule

// File: rtl/hbr_irqmap.sv
module hbr_irqmap
    import hbr_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wen_bit,
    output logic [DATA_W-1:0] rdata,
    output logic [N-1:0]      en_o
);
    logic [N-1:0] en_q;

    for (genvar k = 0; k < N; k++) begin : g_map
        always_ff @(posedge clk) begin
            if (cold_rst || rst) begin
                en_q[k] <= 1'b0;
            end else if (we && idx == IDX_W'(k)) begin
                en_q[k] <= wen_bit;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < N; k++) begin
            if (idx == IDX_W'(k)) rdata = {en_q[k], imap_fixed(k)};
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/hbr_rstctl.sv
module hbr_rstctl
    import hbr_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic             rst,
    input  logic             we,
    input  logic [RC_W-1:0]  wbits,
    output logic [RC_W-1:0]  ctl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             req_o,
    output logic             first_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [RC_W-1:0]  ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             req_q;

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            ctl_q <= RC_POR_VALUE;
            cnt_q <= CNT_W'(1);
            req_q <= 1'b0;
        end else if (rst) begin
            if (cnt_q == '0) ctl_q <= RC_POR_VALUE;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
            req_q <= 1'b0;
        end else if (we) begin
            ctl_q <= rc_apply(ctl_q, wbits);
            req_q <= wbits[RC_SOFT_POR] | wbits[RC_SOFT_XIR];
            if (wbits[RC_SOFT_POR]) cnt_q <= '0;
        end else begin
            req_q <= 1'b0;
        end
    end

    assign ctl_o   = ctl_q;
    assign cnt_o   = cnt_q;
    assign req_o   = req_q;
    assign first_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/hbr_ctl_regs.sv
module hbr_ctl_regs
    import hbr_pkg::*;
#(
    parameter int XLAT_N = 3,
    parameter int PCTL_N = 12,
    parameter int IMAP_N = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              cold_rst,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_reset_req,
    output logic              first_reset
);
    decode_t           dec;
    logic [DATA_W-1:0] xlat_rd;
    logic [DATA_W-1:0] pctl_rd;
    logic [DATA_W-1:0] imap_rd;
    logic [IMAP_N-1:0] imap_en;
    logic [RC_W-1:0]   rc_ctl;
    logic [CNT_W-1:0]  rc_cnt;
    logic              xlat_we;
    logic              pctl_we;
    logic              imap_we;
    logic              rctl_we;

    hbr_decode #(.XLAT_N(XLAT_N), .PCTL_N(PCTL_N), .IMAP_N(IMAP_N)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    assign xlat_we = bus_we && (dec.region == RG_XLAT);
    assign pctl_we = bus_we && (dec.region == RG_PCTL);
    assign imap_we = bus_we && (dec.region == RG_IMAP);
    assign rctl_we = bus_we && (dec.region == RG_RCTL);

    hbr_wordbank #(.N(XLAT_N)) u_xlat (
        .clk      (clk),
        .cold_rst (cold_rst),
        .we       (xlat_we),
        .idx      (dec.idx),
        .wdata    (bus_wdata),
        .rdata    (xlat_rd)
    );

    hbr_wordbank #(.N(PCTL_N)) u_pctl (
        .clk      (clk),
        .cold_rst (cold_rst),
        .we       (pctl_we),
        .idx      (dec.idx),
        .wdata    (bus_wdata),
        .rdata    (pctl_rd)
    );

    hbr_irqmap #(.N(IMAP_N)) u_imap (
        .clk      (clk),
        .cold_rst (cold_rst),
        .rst      (rst),
        .we       (imap_we),
        .idx      (dec.idx),
        .wen_bit  (bus_wdata[DATA_W-1]),
        .rdata    (imap_rd),
        .en_o     (imap_en)
    );

    hbr_rstctl #(.CNT_W(CNT_W)) u_rctl (
        .clk      (clk),
        .cold_rst (cold_rst),
        .rst      (rst),
        .we       (rctl_we),
        .wbits    (bus_wdata[DATA_W-1:DATA_W-RC_W]),
        .ctl_o    (rc_ctl),
        .cnt_o    (rc_cnt),
        .req_o    (sys_reset_req),
        .first_o  (first_reset)
    );

    always_comb begin
        unique case (dec.region)
            RG_XLAT: bus_rdata = xlat_rd;
            RG_PCTL: bus_rdata = pctl_rd;
            RG_IMAP: bus_rdata = imap_rd;
            RG_RCTL: bus_rdata = {rc_ctl, {(DATA_W-RC_W){1'b0}}};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hbr_ctl_regs_chk.sv
module hbr_ctl_regs_chk #(
    parameter int IMAP_N = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              cold_rst,
    input logic              rst,
    input logic [15:0]       bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              sys_reset_req,
    input logic              first_reset,
    input logic [IMAP_N-1:0] imap_en,
    input logic [CNT_W-1:0]  rc_cnt,
    input logic [4:0]        rc_ctl
);
    logic at_rctl;
    assign at_rctl = (bus_addr >= 16'hF024) && (bus_addr <= 16'hF027);

    a_r7_req_has_cause: assert property (@(posedge clk) disable iff (cold_rst)
        sys_reset_req |-> $past(bus_we && at_rctl && !rst && (bus_wdata[30] || bus_wdata[29])));

    a_r7_req_follows: assert property (@(posedge clk) disable iff (cold_rst || rst)
        (bus_we && at_rctl && (bus_wdata[30] || bus_wdata[29])) |=> sys_reset_req);

    a_r9_cold_first: assert property (@(posedge clk) disable iff (rst)
        cold_rst |=> (first_reset && rc_ctl == 5'b10000));

    a_r10_no_wrap: assert property (@(posedge clk) disable iff (cold_rst)
        (rc_cnt != '0 && !(bus_we && at_rctl && !rst && bus_wdata[30])) |=> rc_cnt != '0);

    a_r4_warm_drops_en: assert property (@(posedge clk) disable iff (cold_rst)
        rst |=> imap_en == '0);

    a_r6_set_bit_sticky: assert property (@(posedge clk) disable iff (cold_rst || rst)
        rc_ctl[3] |=> rc_ctl[3]);

    a_r5_dead_word_zero: assert property (@(posedge clk) disable iff (cold_rst)
        (bus_addr >= 16'hF020 && bus_addr <= 16'hF023) |-> bus_rdata == 32'h0);

    a_r2_err_window_zero: assert property (@(posedge clk) disable iff (cold_rst)
        (bus_addr >= 16'h0030 && bus_addr <= 16'h004F) |-> bus_rdata == 32'h0);
endmodule

bind hbr_ctl_regs hbr_ctl_regs_chk #(.IMAP_N(IMAP_N), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .cold_rst      (cold_rst),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .sys_reset_req (sys_reset_req),
    .first_reset   (first_reset),
    .imap_en       (imap_en),
    .rc_cnt        (rc_cnt),
    .rc_ctl        (rc_ctl)
);

// File: tb/hbr_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module hbr_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        cold_rst = 1'b1;
    logic        rst = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        sys_reset_req;
    logic        first_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hbr_ctl_regs dut_i (
        .clk           (clk),
        .cold_rst      (cold_rst),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .sys_reset_req (sys_reset_req),
        .first_reset   (first_reset)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic warm();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic cold();
        @(negedge clk); cold_rst = 1'b1;
        @(negedge clk); cold_rst = 1'b0;
    endtask

    // Reset word write, then check the pulse in the next cycle and its end.
    task automatic wr_rc(input string req, input logic [31:0] d, input logic exp_pulse);
        wr(16'hF024, d);
        chk(req, {31'h0, sys_reset_req}, {31'h0, exp_pulse});
        @(negedge clk);
        chk(req, {31'h0, sys_reset_req}, 32'h0);
    endtask

    task automatic t_reset_state();
        rd_chk("R9 cold reset word", 16'hF024, 32'h8000_0000);
        chk("R9 cold first_reset", {31'h0, first_reset}, 32'h1);
        chk("R7 no request after cold", {31'h0, sys_reset_req}, 32'h0);
        rd_chk("R4 map0 default", 16'h0C04, 32'h0000_07C0);
        rd_chk("R4 map1 default", 16'h0C0C, 32'h0000_07C4);
        rd_chk("R4 map7 default", 16'h0C3C, 32'h0000_07DC);
        rd_chk("R1 xlat0 cold", 16'h0200, 32'h0);
    endtask

    task automatic t_xlat();
        wr(16'h0200, 32'h1111_0001);
        wr(16'h0204, 32'h2222_0002);
        wr(16'h0208, 32'h3333_0003);
        rd_chk("R1 xlat0", 16'h0200, 32'h1111_0001);
        rd_chk("R1 xlat1", 16'h0204, 32'h2222_0002);
        rd_chk("R1 xlat2", 16'h0208, 32'h3333_0003);
        wr(16'h020C, 32'hFFFF_FFFF);
        wr(16'h03FC, 32'hFFFF_FFFF);
        rd_chk("R2 flush reads zero", 16'h020C, 32'h0);
        rd_chk("R2 flush end reads zero", 16'h03FC, 32'h0);
        rd_chk("R2 flush no alias xlat2", 16'h0208, 32'h3333_0003);
        rd_chk("R2 flush no alias xlat0", 16'h0200, 32'h1111_0001);
    endtask

    task automatic t_pctl();
        for (int k = 0; k < 12; k++) wr(16'h2000 + 16'(4 * k), 32'hA500_0000 | 32'(k * 17));
        for (int k = 0; k < 12; k++) rd_chk("R3 pci control word", 16'h2000 + 16'(4 * k), 32'hA500_0000 | 32'(k * 17));
        wr(16'h2030, 32'hDEAD_BEEF);
        rd_chk("R3 past bank reads zero", 16'h2030, 32'h0);
        rd_chk("R3 last word unchanged", 16'h202C, 32'hA500_0000 | 32'(11 * 17));
    endtask

    task automatic t_imap();
        wr(16'h0C04, 32'hFFFF_FFFF);
        rd_chk("R4 only enable bit written", 16'h0C04, 32'h8000_07C0);
        wr(16'h0C00, 32'hFFFF_FFFF);
        rd_chk("R4 dead half reads zero", 16'h0C00, 32'h0);
        rd_chk("R4 dead half no alias", 16'h0C04, 32'h8000_07C0);
        rd_chk("R4 neighbour untouched", 16'h0C0C, 32'h0000_07C4);
        wr(16'h0C04, 32'h0000_0000);
        rd_chk("R4 enable cleared by write", 16'h0C04, 32'h0000_07C0);
        wr(16'h0C14, 32'h8000_0000);
        rd_chk("R4 map2 enabled", 16'h0C14, 32'h8000_07C8);
        warm();
        rd_chk("R4 warm reset drops enable", 16'h0C14, 32'h0000_07C8);
    endtask

    task automatic t_unmapped();
        wr(16'h0030, 32'hFFFF_FFFF);
        wr(16'h0040, 32'hFFFF_FFFF);
        wr(16'h5000, 32'hFFFF_FFFF);
        wr(16'hA400, 32'hFFFF_FFFF);
        wr(16'hA800, 32'hFFFF_FFFF);
        wr(16'hF000, 32'hFFFF_FFFF);
        wr(16'h1234, 32'hFFFF_FFFF);
        rd_chk("R2 dma error reads zero", 16'h0030, 32'h0);
        rd_chk("R2 dma error end reads zero", 16'h004C, 32'h0);
        rd_chk("R2 diag reads zero", 16'h5000, 32'h0);
        rd_chk("R2 iommu diag reads zero", 16'hA400, 32'h0);
        rd_chk("R2 irq diag reads zero", 16'hA800, 32'h0);
        rd_chk("R2 mem ctl reads zero", 16'hF000, 32'h0);
        rd_chk("R2 unlisted reads zero", 16'h1234, 32'h0);
        rd_chk("R2 xlat intact", 16'h0204, 32'h2222_0002);
        rd_chk("R2 pci ctl intact", 16'h2000, 32'hA500_0000);
    endtask

    task automatic t_rctl();
        cold();
        wr(16'hF020, 32'hFFFF_FFFF);
        chk("R5 dead word no pulse", {31'h0, sys_reset_req}, 32'h0);
        rd_chk("R5 dead word reads zero", 16'hF020, 32'h0);
        rd_chk("R5 dead word no alias", 16'hF024, 32'h8000_0000);
        wr_rc("R5 low bits masked", 32'h07FF_FFFF, 1'b0);
        rd_chk("R5 low bits read zero", 16'hF024, 32'h8000_0000);
        wr_rc("R6 button bits clear no pulse", 32'h1800_0000, 1'b0);
        rd_chk("R6 bit31 kept", 16'hF024, 32'h8000_0000);
        wr_rc("R6 clear power-on bit", 32'h8000_0000, 1'b0);
        rd_chk("R6 power-on bit cleared", 16'hF024, 32'h0);
        wr_rc("R7 soft xir pulse", 32'h2000_0000, 1'b1);
        rd_chk("R6 soft xir bit set", 16'hF024, 32'h2000_0000);
        chk("R8 xir keeps first", {31'h0, first_reset}, 32'h1);
        warm();
        rd_chk("R9 later reset keeps word", 16'hF024, 32'h2000_0000);
        chk("R9 later reset not first", {31'h0, first_reset}, 32'h0);
        wr_rc("R7 soft por pulse", 32'h4000_0000, 1'b1);
        rd_chk("R6 soft por bit set", 16'hF024, 32'h6000_0000);
        chk("R8 por clears counter", {31'h0, first_reset}, 32'h0);
        warm();
        rd_chk("R9 first reset reloads", 16'hF024, 32'h8000_0000);
        chk("R9 first reset flag", {31'h0, first_reset}, 32'h1);
        warm();
        chk("R8 second reset not first", {31'h0, first_reset}, 32'h0);
        wr_rc("R8 both bits pulse", 32'h6000_0000, 1'b1);
        warm();
        rd_chk("R8 both bits acts as por", 16'hF024, 32'h8000_0000);
        chk("R8 both bits first flag", {31'h0, first_reset}, 32'h1);
        wr_rc("R6 clear all clear-on-one", 32'h9800_0000, 1'b0);
        rd_chk("R6 all cleared", 16'hF024, 32'h0);
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 20; i++) begin
            warm();
            chk("R10 no wrap to first", {31'h0, first_reset}, 32'h0);
        end
        rd_chk("R10 word not reloaded", 16'hF024, 32'h0);
    endtask

    task automatic t_preserve();
        wr(16'h0208, 32'h5A5A_A5A5);
        warm();
        rd_chk("R1 xlat kept across warm", 16'h0208, 32'h5A5A_A5A5);
        cold();
        rd_chk("R1 xlat cleared by cold", 16'h0208, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cold_rst = 1'b0;
        t_reset_state();
        t_xlat();
        t_pctl();
        t_imap();
        t_unmapped();
        t_rctl();
        t_saturate();
        t_preserve();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule